// File: doc/BRIEF.md
# Block Address Translation Matcher

This block sits in front of page translation and decides, for every memory access, whether one of a few fixed block mappings covers the effective address. It holds two banks of register pairs, one searched by instruction fetches and one by data accesses. Each pair has an upper word and a lower word. The upper word holds a block index and a block-length mask. The lower word holds the physical block number. When a valid pair matches, the block replaces the masked-off upper address bits with that pair's physical block number. When no pair matches, the access is flagged so that the page translation path handles it. When translation is off, the address passes through untouched.

Validity follows one of two register layouts, chosen by a strap. In the legacy layout, one bit of the lower word marks the pair as live. In the standard layout, the upper word carries a supervisor-valid bit and a user-valid bit. The pair is then live only for the privilege state whose bit is set.

Lookups travel as a stream. A request is taken on a cycle where `req_valid` and `req_ready` are both high. Its result appears on the response port on the following cycle. The response stays on the port, unchanged, until `rsp_ready` accepts it. While an unaccepted response is held, `req_ready` is low, so a stalled consumer throttles the producer with no loss and no reordering. The register write port and the straps are plain control pins.

Top module: `bat_xlate_matcher`

## Requirements
- R1: A request is taken when `req_valid` and `req_ready` are both high, and its response is presented with `rsp_valid` high on the next cycle. `req_ready` is high exactly when no response is held or `rsp_ready` is high. A held response keeps `rsp_pa`, `rsp_hit` and `rsp_miss` stable until it is taken.
- R2: A request taken with `xlat_en` low returns `rsp_pa` equal to `req_ea`, with `rsp_hit` and `rsp_miss` both low, whatever the registers contain.
- R3: `req_instr` high searches only the instruction bank (`cfg_instr_set`=1), and low searches only the data bank. A pair in the other bank never produces a hit.
- R4: With `cfg_legacy` high, a pair is live exactly when bit 0 of its lower word is set. Bits 1 and 0 of the upper word have no effect.
- R5: With `cfg_legacy` low, a pair is live when (upper bit 1 and not `req_user`) or (upper bit 0 and `req_user`). Bit 1 is supervisor-valid, bit 0 is user-valid, and bit 0 of the lower word has no effect.
- R6: Writing zero to a pair's lower word (legacy layout) or upper word (standard layout) makes that pair miss for every address and privilege state.
- R7: A live pair matches when the top IDXW address bits equal the upper word's top IDXW bits. The comparison ignores index bit i for every set bit i of the mask field, upper bits [MSKW+1:2].
- R8: On a hit, each of the top IDXW bits of `rsp_pa` comes from the lower word's top IDXW bits where the mask bit is clear, and from the address where it is set. The low AW-IDXW bits pass from `req_ea` unchanged.
- R9: When several live pairs match, the lowest-numbered pair supplies the translation.
- R10: With `xlat_en` high and no live matching pair, `rsp_miss` is high, `rsp_hit` is low and `rsp_pa` is zero. `rsp_hit` and `rsp_miss` are never high together.
- R11: After reset, every register word is zero, `rsp_valid` is low and `req_ready` is high.
- R12: A register write changes the addressed word at the clock edge. A request taken on any later edge sees the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xlat_en | input | 1 | Translation enable; low selects pass-through |
| cfg_legacy | input | 1 | Layout strap: 1 legacy, 0 standard |
| cfg_we | input | 1 | Register write strobe |
| cfg_instr_set | input | 1 | Write target bank: 1 instruction, 0 data |
| cfg_pair | input | $clog2(NPAIR) | Pair number written |
| cfg_upper | input | 1 | 1 writes the upper word, 0 the lower word |
| cfg_wdata | input | AW | Write data |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_ea | input | AW | Effective address |
| req_user | input | 1 | Privilege state: 1 user, 0 supervisor |
| req_instr | input | 1 | Access type: 1 instruction fetch, 0 data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_pa | output | AW | Translated or passed-through address |
| rsp_hit | output | 1 | A block pair translated the address |
| rsp_miss | output | 1 | Hand the access to page translation |

## Verification
The bench builds the block with AW=16, IDXW=6, MSKW=3 and NPAIR=4. This leaves a 6-bit block index with up to 3 ignorable bits, so every index value can be swept for each register setting. The sweep runs against both banks, both privilege states, both layouts and both translation settings. The register contents are drawn pseudo-randomly, and in every third setting all pairs share one index, which forces overlapping matches and exercises priority. Directed sequences cover stalls on the response port, the separation between banks, each valid bit in each layout, and invalidation by a zero write.

// File: rtl/bat_pkg.sv
package bat_pkg;

  typedef enum logic {
    FMT_STANDARD = 1'b0,
    FMT_LEGACY   = 1'b1
  } bat_fmt_e;

  // Liveness of one pair under the selected register layout.
  function automatic logic pair_live(
    input bat_fmt_e fmt,
    input logic     lower_v,
    input logic     sup_ok,
    input logic     usr_ok,
    input logic     user
  );
    if (fmt == FMT_LEGACY) return lower_v;
    return (sup_ok && !user) || (usr_ok && user);
  endfunction

endpackage

// File: rtl/bat_regfile.sv
module bat_regfile #(
  parameter int AW    = 32,
  parameter int NPAIR = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [$clog2(NPAIR)-1:0]      pair,
  input  logic                          upper_sel,
  input  logic [AW-1:0]                 wdata,
  output logic [NPAIR-1:0][AW-1:0]      upper_q,
  output logic [NPAIR-1:0][AW-1:0]      lower_q
);

  for (genvar k = 0; k < NPAIR; k++) begin : gen_pair
    logic hit_k;
    assign hit_k = we && (pair == k);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        upper_q[k] <= '0;
        lower_q[k] <= '0;
      end else if (hit_k) begin
        if (upper_sel) upper_q[k] <= wdata;
        else           lower_q[k] <= wdata;
      end
    end

    AST_WRITE_LANDS_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (we && pair == k && upper_sel) |=> (upper_q[k] == $past(wdata))); // R12
    AST_WRITE_LANDS_LO: assert property (@(posedge clk) disable iff (!rst_n)
      (we && pair == k && !upper_sel) |=> (lower_q[k] == $past(wdata))); // R12
  end

endmodule

// File: rtl/bat_pair_match.sv
module bat_pair_match
  import bat_pkg::*;
#(
  parameter int IDXW = 15,
  parameter int MSKW = 11
) (
  input  logic [IDXW-1:0] blk_idx,
  input  logic [MSKW-1:0] blk_mask,
  input  logic            sup_ok,
  input  logic            usr_ok,
  input  logic [IDXW-1:0] pbn,
  input  logic            lower_v,
  input  bat_fmt_e        fmt,
  input  logic            user,
  input  logic [IDXW-1:0] ea_hi,
  output logic            hit,
  output logic [IDXW-1:0] pa_hi
);

  localparam int PADW = IDXW - MSKW;

  logic [IDXW-1:0] ign;
  logic            live;

  assign ign = {{PADW{1'b0}}, blk_mask};

  always_comb begin
    live  = pair_live(fmt, lower_v, sup_ok, usr_ok, user);
    hit   = live && (((ea_hi ^ blk_idx) & ~ign) == '0);
    pa_hi = (pbn & ~ign) | (ea_hi & ign);
  end

endmodule

// File: rtl/bat_priority_sel.sv
module bat_priority_sel #(
  parameter int NPAIR = 4,
  parameter int IDXW  = 15
) (
  input  logic [NPAIR-1:0]            match,
  input  logic [NPAIR-1:0][IDXW-1:0]  cand,
  output logic                        any,
  output logic [IDXW-1:0]             pick
);

  // Scan from the top down so the lowest-numbered match is written last.
  always_comb begin
    any  = 1'b0;
    pick = '0;
    for (int k = NPAIR - 1; k >= 0; k--) begin
      if (match[k]) begin
        any  = 1'b1;
        pick = cand[k];
      end
    end
  end

endmodule

// File: rtl/bat_xlate_matcher.sv
module bat_xlate_matcher
  import bat_pkg::*;
#(
  parameter int AW    = 32,
  parameter int IDXW  = 15,
  parameter int MSKW  = 11,
  parameter int NPAIR = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     xlat_en,
  input  logic                     cfg_legacy,
  input  logic                     cfg_we,
  input  logic                     cfg_instr_set,
  input  logic [$clog2(NPAIR)-1:0] cfg_pair,
  input  logic                     cfg_upper,
  input  logic [AW-1:0]            cfg_wdata,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [AW-1:0]            req_ea,
  input  logic                     req_user,
  input  logic                     req_instr,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [AW-1:0]            rsp_pa,
  output logic                     rsp_hit,
  output logic                     rsp_miss
);

  localparam int OFFW  = AW - IDXW;
  localparam int NSET  = 2;
  localparam int MLO   = 2;
  localparam int MHI   = MSKW + 1;
  localparam int GAPW  = OFFW - MHI - 1;

  // Register banks: index 1 instruction, index 0 data.
  logic [NSET-1:0][NPAIR-1:0][AW-1:0] up_q;
  logic [NSET-1:0][NPAIR-1:0][AW-1:0] lo_q;

  for (genvar s = 0; s < NSET; s++) begin : gen_set
    logic we_s;
    assign we_s = cfg_we && (cfg_instr_set == s[0]);

    bat_regfile #(.AW(AW), .NPAIR(NPAIR)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (we_s),
      .pair      (cfg_pair),
      .upper_sel (cfg_upper),
      .wdata     (cfg_wdata),
      .upper_q   (up_q[s]),
      .lower_q   (lo_q[s])
    );
  end

  // Searched bank.
  logic [NPAIR-1:0][AW-1:0] up_s;
  logic [NPAIR-1:0][AW-1:0] lo_s;
  assign up_s = req_instr ? up_q[1] : up_q[0];
  assign lo_s = req_instr ? lo_q[1] : lo_q[0];

  bat_fmt_e        fmt;
  logic [IDXW-1:0] ea_hi;
  assign fmt   = cfg_legacy ? FMT_LEGACY : FMT_STANDARD;
  assign ea_hi = req_ea[AW-1 -: IDXW];

  logic [NPAIR-1:0]           match;
  logic [NPAIR-1:0][IDXW-1:0] cand;

  for (genvar k = 0; k < NPAIR; k++) begin : gen_cmp
    logic [GAPW-1:0] unused_up_gap;
    logic [OFFW-2:0] unused_lo_gap;
    assign unused_up_gap = up_s[k][OFFW-1:MHI+1];
    assign unused_lo_gap = lo_s[k][OFFW-1:1];

    bat_pair_match #(.IDXW(IDXW), .MSKW(MSKW)) u_cmp (
      .blk_idx  (up_s[k][AW-1 -: IDXW]),
      .blk_mask (up_s[k][MHI:MLO]),
      .sup_ok   (up_s[k][1]),
      .usr_ok   (up_s[k][0]),
      .pbn      (lo_s[k][AW-1 -: IDXW]),
      .lower_v  (lo_s[k][0]),
      .fmt      (fmt),
      .user     (req_user),
      .ea_hi    (ea_hi),
      .hit      (match[k]),
      .pa_hi    (cand[k])
    );
  end

  logic            any_hit;
  logic [IDXW-1:0] pick_hi;

  bat_priority_sel #(.NPAIR(NPAIR), .IDXW(IDXW)) u_pick (
    .match (match),
    .cand  (cand),
    .any   (any_hit),
    .pick  (pick_hi)
  );

  // Result for the request now on the input.
  logic [AW-1:0] nxt_pa;
  logic          nxt_hit;
  logic          nxt_miss;

  always_comb begin
    nxt_pa   = req_ea;
    nxt_hit  = 1'b0;
    nxt_miss = 1'b0;
    if (xlat_en) begin
      if (any_hit) begin
        nxt_pa  = {pick_hi, req_ea[OFFW-1:0]};
        nxt_hit = 1'b1;
      end else begin
        nxt_pa   = '0;
        nxt_miss = 1'b1;
      end
    end
  end

  // Output stage with back-pressure.
  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_pa    <= '0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
    end else if (req_ready) begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_pa   <= nxt_pa;
        rsp_hit  <= nxt_hit;
        rsp_miss <= nxt_miss;
      end
    end
  end

  AST_TAKE_THEN_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid); // R1
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa) && $stable(rsp_hit) && $stable(rsp_miss))); // R1
  AST_BYPASS_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !xlat_en) |=> (rsp_pa == $past(req_ea) && !rsp_hit && !rsp_miss)); // R2
  AST_OFFSET_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && xlat_en) |=> (rsp_hit || rsp_miss)); // R10
  AST_HIT_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && xlat_en && any_hit) |=> (rsp_pa[OFFW-1:0] == $past(req_ea[OFFW-1:0]))); // R8
  AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_hit && rsp_miss)); // R10

endmodule

// File: tb/bat_xlate_matcher_bench.sv
module bat_xlate_matcher_bench;

  localparam int AW    = 16;
  localparam int IDXW  = 6;
  localparam int MSKW  = 3;
  localparam int NPAIR = 4;
  localparam int OFFW  = AW - IDXW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rst_n = 1'b0;
  logic            xlat_en = 1'b0;
  logic            cfg_legacy = 1'b0;
  logic            cfg_we = 1'b0;
  logic            cfg_instr_set = 1'b0;
  logic [1:0]      cfg_pair = '0;
  logic            cfg_upper = 1'b0;
  logic [AW-1:0]   cfg_wdata = '0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [AW-1:0]   req_ea = '0;
  logic            req_user = 1'b0;
  logic            req_instr = 1'b0;
  logic            rsp_valid;
  logic            rsp_ready = 1'b1;
  logic [AW-1:0]   rsp_pa;
  logic            rsp_hit;
  logic            rsp_miss;

  bat_xlate_matcher #(.AW(AW), .IDXW(IDXW), .MSKW(MSKW), .NPAIR(NPAIR)) u_bat_xlate_matcher (
    .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en), .cfg_legacy(cfg_legacy),
    .cfg_we(cfg_we), .cfg_instr_set(cfg_instr_set), .cfg_pair(cfg_pair),
    .cfg_upper(cfg_upper), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_ea(req_ea),
    .req_user(req_user), .req_instr(req_instr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(rsp_pa),
    .rsp_hit(rsp_hit), .rsp_miss(rsp_miss)
  );

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [AW-1:0] sh_up [2][NPAIR];
  logic [AW-1:0] sh_lo [2][NPAIR];
  logic [31:0]   lfsr = 32'h1ACE_B00C;

  function automatic logic [31:0] step(input logic [31:0] v);
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  task automatic check(input string tag, input logic [AW+1:0] act, input logic [AW+1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit iset, input int p, input bit up, input logic [AW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_instr_set = iset; cfg_pair = p[1:0]; cfg_upper = up; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (up) sh_up[iset][p] = d;
    else    sh_lo[iset][p] = d;
  endtask

  // Expected {hit, miss, pa}; win returns the chosen pair or -1.
  function automatic logic [AW+1:0] model(input logic [AW-1:0] ea, input bit user, input bit instr,
                                         input bit legacy, input bit xl, output int win);
    logic [IDXW-1:0] ign, hi;
    bit live;
    win = -1;
    if (!xl) return {2'b00, ea};
    for (int k = 0; k < NPAIR; k++) begin
      ign  = IDXW'(sh_up[instr][k][MSKW+1:2]);
      live = legacy ? sh_lo[instr][k][0]
                    : ((sh_up[instr][k][1] && !user) || (sh_up[instr][k][0] && user));
      if (win < 0 && live && (((ea[AW-1 -: IDXW] ^ sh_up[instr][k][AW-1 -: IDXW]) & ~ign) == 0)) begin
        win = k;
        hi  = (sh_lo[instr][k][AW-1 -: IDXW] & ~ign) | (ea[AW-1 -: IDXW] & ign);
      end
    end
    if (win < 0) return {2'b01, {AW{1'b0}}};
    return {2'b10, hi, ea[OFFW-1:0]};
  endfunction

  task automatic look(input logic [AW-1:0] ea, input bit user, input bit instr,
                      input bit legacy, input bit xl, input string tag, input logic [AW+1:0] exp);
    @(negedge clk);
    req_valid = 1'b1; req_ea = ea; req_user = user; req_instr = instr;
    cfg_legacy = legacy; xlat_en = xl; rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (!rsp_valid) begin
      n_fail++;
      $display("FAIL R1 rsp_valid actual=0 expected=1");
    end
    check(tag, {rsp_hit, rsp_miss, rsp_pa}, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int w;
    logic [AW+1:0] e;
    for (int s = 0; s < 2; s++)
      for (int k = 0; k < NPAIR; k++) begin sh_up[s][k] = '0; sh_lo[s][k] = '0; end

    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 rsp_valid/req_ready", {16'h0, rsp_valid, req_ready}, {16'h0, 2'b01});
    rst_n = 1'b1;
    look(16'h1234, 0, 0, 0, 1, "R11 empty regs miss", {2'b01, 16'h0000});
    look(16'h1234, 0, 1, 1, 1, "R11 empty regs miss legacy", {2'b01, 16'h0000});

    // R3: instruction bank pair 0, index 5, no mask, both valid bits and V set
    wr(1, 0, 1, 16'h1403);
    wr(1, 0, 0, 16'hA801);
    look(16'h17FF, 0, 1, 0, 1, "R3/R8 instr bank hit", {2'b10, 16'hABFF});
    look(16'h17FF, 0, 0, 0, 1, "R3 data bank misses", {2'b01, 16'h0000});
    look(16'h17FF, 1, 0, 1, 1, "R3 data bank misses legacy", {2'b01, 16'h0000});

    // R4: legacy ignores upper valid bits, uses lower bit 0
    look(16'h1400, 1, 1, 1, 1, "R4 legacy live", {2'b10, 16'hA800});
    wr(1, 0, 0, 16'hA800);
    look(16'h1400, 1, 1, 1, 1, "R4 legacy V clear miss", {2'b01, 16'h0000});
    // R5: standard ignores lower bit 0
    look(16'h1400, 1, 1, 0, 1, "R5 standard ignores lower V", {2'b10, 16'hA800});
    wr(1, 0, 1, 16'h1402);
    look(16'h1400, 0, 1, 0, 1, "R5 supervisor bit, supervisor", {2'b10, 16'hA800});
    look(16'h1400, 1, 1, 0, 1, "R5 supervisor bit, user", {2'b01, 16'h0000});
    wr(1, 0, 1, 16'h1401);
    look(16'h1400, 1, 1, 0, 1, "R5 user bit, user", {2'b10, 16'hA800});
    look(16'h1400, 0, 1, 0, 1, "R5 user bit, supervisor", {2'b01, 16'h0000});

    // R6: zero writes invalidate
    wr(1, 0, 1, 16'h0000);
    look(16'h0000, 0, 1, 0, 1, "R6 upper zero standard sup", {2'b01, 16'h0000});
    look(16'h0000, 1, 1, 0, 1, "R6 upper zero standard usr", {2'b01, 16'h0000});
    wr(1, 0, 1, 16'h1403);
    wr(1, 0, 0, 16'hA801);
    look(16'h1400, 0, 1, 1, 1, "R12 rewrite visible", {2'b10, 16'hA800});
    wr(1, 0, 0, 16'h0000);
    look(16'h1400, 0, 1, 1, 1, "R6 lower zero legacy", {2'b01, 16'h0000});

    // R1: stall holds response and blocks input
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_ea = 16'hBEEF; xlat_en = 1'b0;
    @(negedge clk);
    req_ea = 16'h5A5A;
    check("R1 ready low while held", {17'h0, req_ready}, {17'h0, 1'b0});
    @(negedge clk);
    check("R1 held response stable", {rsp_valid, rsp_hit, rsp_pa}, {2'b10, 16'hBEEF});
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R1 next after release", {rsp_valid, rsp_hit, rsp_pa}, {2'b10, 16'h5A5A});
    @(negedge clk);
    check("R1 drained", {17'h0, rsp_valid}, {18'h0});

    // Sweep: R2 R7 R8 R9 R10 over many register settings
    for (int c = 0; c < 30; c++) begin
      logic [5:0] base;
      lfsr = step(lfsr);
      base = lfsr[5:0];
      for (int s = 0; s < 2; s++)
        for (int k = 0; k < NPAIR; k++) begin
          logic [5:0] ix;
          lfsr = step(lfsr);
          ix = (c % 3 == 0) ? base : lfsr[15:10];
          wr(s[0], k, 1, {ix, 5'b0, lfsr[4:2], lfsr[1:0]});
          lfsr = step(lfsr);
          wr(s[0], k, 0, {lfsr[15:10], 9'b0, lfsr[0]});
        end
      for (int h = 0; h < 64; h++)
        for (int m = 0; m < 16; m++) begin
          logic [AW-1:0] ea;
          string tg;
          lfsr = step(lfsr);
          ea = {h[5:0], lfsr[9:0]};
          e = model(ea, m[0], m[1], m[2], m[3], w);
          if (!m[3])      tg = "R2 bypass";
          else if (w > 0) tg = "R9 lowest pair wins";
          else if (w == 0) tg = "R7/R8 match and splice";
          else            tg = "R10 miss";
          look(ea, m[0], m[1], m[2], m[3], tg, e);
        end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule